// File: doc/BRIEF.md
# Qualified Input Edge Counter

This block counts transitions on an external pin that is not related to the system clock. The pin first passes through a two-flop synchronizer. A qualifier then accepts a new level only after that level has been sampled on two consecutive clock edges. An edge is recognised only when a qualified level is replaced by a qualified level of the opposite polarity. A narrow glitch therefore never counts, and the highest input rate that counts reliably is one quarter of the clock rate.

A two-bit select input picks which qualified edges advance the counter: rising, falling, both or none. An enable input gates counting. A clear input zeroes the counter and takes priority over an increment. Each counted edge also gives a one-cycle pulse in the cycle the new count appears.

Top module: `edge_tally_top`

## Requirements
- R1: During and right after synchronous reset, the count output is zero and the pulse output is low.
- R2: A pin level is accepted only when it is sampled on two consecutive clock edges. A pulse of the opposite level that lasts one sample changes nothing and is not counted.
- R3: The first level accepted after reset only sets the reference level and is never counted. Counting starts with the first accepted level of the opposite polarity.
- R4: Select encoding: 2'b00 counts nothing, 2'b01 counts rising edges only, 2'b10 counts falling edges only, 2'b11 counts both.
- R5: With rising edges selected, a rising edge counts only when a low level lasting at least two samples was accepted before it. A shorter low dip followed by high gives no count.
- R6: When the pin takes its new level before clock edge k and keeps it, the count increment and the pulse both appear after edge k+4.
- R7: A pin that toggles every two clock cycles (a quarter of the clock rate) with both edges selected counts every one of its edges.
- R8: While the enable input is low, accepted edges change neither the count nor the pulse output.
- R9: When the clear input is high at a clock edge, the count becomes zero after that edge. This also holds when an increment falls in the same cycle.
- R10: The count is CNT_W bits wide (16 by default) and wraps from all ones to zero.
- R11: The pulse output is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pin_i | input | 1 | Raw external pin, asynchronous |
| sel_i | input | 2 | Edge select (none, rising, falling, both) |
| en_i | input | 1 | Counting enable |
| clr_i | input | 1 | Synchronous counter clear, wins over an increment |
| cnt_o | output | CNT_W | Edge count |
| hit_o | output | 1 | One-cycle pulse per counted edge |

## Verification
Two cases are the hardest to reach from the ports. The first is a clear that lands in exactly the cycle where an increment also lands. The stimulus changes the pin and then raises clear four falling edges later, so that it is sampled at the same edge as the pending increment. The second is a dip that lasts a single sample in rising-only mode, placed between two long high levels. It proves that dropping falling-edge counting does not shorten the low time that must be accepted. At-rate toggling across a counter wrap is driven with a narrowed counter so the wrap happens within the run.

// File: rtl/edge_tally_pkg.sv
package edge_tally_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_BOTH = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/et_sync.sv
// Multi-stage synchronizer with a fill flag that marks when the
// output stage carries a real pin sample rather than the reset value.
module et_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic smp_o,
    output logic vld_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic [STAGES-1:0] fill;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh[0]   = pin_i;
        st_d.fill[0] = 1'b1;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sh[i]   = st_q.sh[i-1];
            st_d.fill[i] = st_q.fill[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign smp_o = st_q.sh[STAGES-1];
    assign vld_o = st_q.fill[STAGES-1];

    // R3: the output stage only reports valid once it has been filled from the pin
    a_r3_fill_monotonic: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o |=> vld_o);
endmodule

// File: rtl/et_qual.sv
// Level qualifier: accepts a level after QUAL equal samples in a row and
// flags a transition between two accepted levels of opposite polarity.
module et_qual #(
    parameter int QUAL = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic smp_i,
    input  logic vld_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int RW = $clog2(QUAL + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(QUAL);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          last;
        logic          lvl;
        logic          lvl_ok;
        logic          rise;
        logic          fall;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (vld_i) begin
            if (st_q.run != '0 && smp_i == st_q.last) begin
                if (st_q.run < RUN_MAX) st_d.run = st_q.run + 1'b1;
            end else begin
                st_d.run = RW'(1);
            end
            st_d.last = smp_i;
            if (st_d.run == RUN_MAX && (!st_q.lvl_ok || st_q.lvl != smp_i)) begin
                st_d.lvl    = smp_i;
                st_d.lvl_ok = 1'b1;
                st_d.rise   = st_q.lvl_ok & smp_i;
                st_d.fall   = st_q.lvl_ok & ~smp_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

    a_r2_one_direction: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({rise_o, fall_o}));

    // R2: an edge event follows two equal synchronized samples
    a_r2_two_samples: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_o || fall_o) |-> ($past(smp_i) == $past(smp_i, 2)));

    a_r2_rise_level: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |-> $past(smp_i));

    a_r11_event_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_o || fall_o) |=> !(rise_o || fall_o));
endmodule

// File: rtl/et_count.sv
// Selected-edge counter with enable, clear priority and a registered pulse.
module et_count
    import edge_tally_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [1:0]       sel_i,
    input  logic             clr_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hit;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    want_rise, want_fall, take;

    always_comb begin
        want_rise = (sel_i == SEL_RISE) || (sel_i == SEL_BOTH);
        want_fall = (sel_i == SEL_FALL) || (sel_i == SEL_BOTH);
        take      = en_i && ((rise_i && want_rise) || (fall_i && want_fall));
        st_d      = st_q;
        st_d.hit  = take;
        if (clr_i)     st_d.cnt = '0;
        else if (take) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign hit_o = st_q.hit;

    a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (cnt_o == '0));

    a_r8_disabled_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !clr_i) |=> ($stable(cnt_o) && !hit_o));

    a_r4_none_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == SEL_NONE) |=> !hit_o);

    a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> !hit_o);
endmodule

// File: rtl/edge_tally_top.sv
module edge_tally_top #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL        = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pin_i,
    input  logic [1:0]       sel_i,
    input  logic             en_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    logic smp, smp_vld, rise, fall;

    et_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .pin_i (pin_i),
        .smp_o (smp),
        .vld_o (smp_vld)
    );

    et_qual #(.QUAL(QUAL)) u_qual (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .smp_i  (smp),
        .vld_i  (smp_vld),
        .rise_o (rise),
        .fall_o (fall)
    );

    et_count #(.CNT_W(CNT_W)) u_count (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .sel_i  (sel_i),
        .clr_i  (clr_i),
        .rise_i (rise),
        .fall_i (fall),
        .cnt_o  (cnt_o),
        .hit_o  (hit_o)
    );

    // R10: an increment without clear moves the count by exactly one, wrapping
    a_r10_step_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (hit_o && !$past(clr_i)) |-> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: tb/tb_edge_tally_top.sv
module tb_edge_tally_top;
    localparam int PERIOD = 10;
    localparam int W      = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pin = 1'b1;
    logic [1:0]   sel = 2'b11;
    logic         en  = 1'b1;
    logic         clr = 1'b0;
    logic [W-1:0] cnt;
    logic         hit;

    edge_tally_top #(.CNT_W(W)) dut (
        .clk_i (clk), .rst_i (rst), .pin_i (pin), .sel_i (sel),
        .en_i (en), .clr_i (clr), .cnt_o (cnt), .hit_o (hit)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        int unsigned  due;
        logic [W-1:0] val;
    } exp_t;

    exp_t         q[$];
    int unsigned  cyc = 0;
    int           total = 0;
    int           bad = 0;
    bit           done = 0;
    bit           m_ok = 0;
    logic         m_lvl = 1'b0;
    logic [W-1:0] m_cnt = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // scoreboard monitor: every pulse must match a queued expectation
    always @(negedge clk) begin
        if (!rst && hit) begin
            if (q.size() == 0) begin
                check(1'b0, "R4/R8 unexpected pulse", int'(cnt), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == e.due, "R6 pulse cycle", int'(cyc), int'(e.due));
                check(cnt == e.val, "R6/R10 count value", int'(cnt), int'(e.val));
            end
        end
    end

    // driver: hold the pin at lvl for n cycles, predicting counted edges
    task automatic hold(input logic lvl, input int n);
        pin = lvl;
        if (n >= 2 && (!m_ok || m_lvl != lvl)) begin
            if (m_ok && en && ((lvl && sel[0]) || (!lvl && sel[1]))) begin
                m_cnt = m_cnt + 1'b1;
                q.push_back('{cyc + 5, m_cnt});
            end
            m_ok  = 1;
            m_lvl = lvl;
        end
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cnt == '0, "R1 count in reset", int'(cnt), 0);
        check(hit == 1'b0, "R1 pulse in reset", int'(hit), 0);
        rst = 1'b0;
        @(negedge clk);
        check(cnt == '0 && !hit, "R1 after reset", int'(cnt), 0);

        // R3: first accepted level is the reference only
        hold(1'b1, 10);
        check(cnt == '0, "R3 first level uncounted", int'(cnt), 0);
        hold(1'b0, 6);
        hold(1'b1, 6);
        settle();
        check(cnt == 8'd2, "R3 counting after reference", int'(cnt), 2);

        // R2: one-sample glitch is ignored
        hold(1'b0, 1);
        hold(1'b1, 8);
        settle();
        check(cnt == 8'd2, "R2 glitch ignored", int'(cnt), 2);

        // R7: toggle every two cycles, both edges
        for (int i = 0; i < 20; i++) begin
            hold(1'b0, 2);
            hold(1'b1, 2);
        end
        settle();
        check(cnt == m_cnt, "R7 quarter rate count", int'(cnt), int'(m_cnt));

        // R5: rising only, short low dip must not count
        sel = 2'b01;
        hold(1'b0, 1);
        hold(1'b1, 8);
        settle();
        check(cnt == m_cnt, "R5 short low dip", int'(cnt), int'(m_cnt));
        hold(1'b0, 2);
        hold(1'b1, 4);
        hold(1'b0, 4);
        settle();
        check(cnt == m_cnt, "R5 qualified low then high", int'(cnt), int'(m_cnt));

        // R4: falling only, then none
        sel = 2'b10;
        hold(1'b1, 4);
        hold(1'b0, 4);
        hold(1'b1, 4);
        settle();
        check(cnt == m_cnt, "R4 falling only", int'(cnt), int'(m_cnt));
        sel = 2'b00;
        begin
            logic [W-1:0] snap;
            snap = cnt;
            for (int i = 0; i < 4; i++) begin
                hold(1'b0, 3);
                hold(1'b1, 3);
            end
            settle();
            check(cnt == snap, "R4 none counts nothing", int'(cnt), int'(snap));
        end

        // R8: enable low
        sel = 2'b11;
        en  = 1'b0;
        for (int i = 0; i < 4; i++) begin
            hold(1'b0, 3);
            hold(1'b1, 3);
        end
        settle();
        check(cnt == m_cnt, "R8 disabled holds", int'(cnt), int'(m_cnt));
        en = 1'b1;

        // R9: idle clear
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_cnt = '0;
        check(cnt == '0, "R9 idle clear", int'(cnt), 0);
        hold(1'b0, 6);
        settle();
        // R9: clear in the same cycle as an increment
        pin = 1'b1;
        m_lvl = 1'b1;
        m_cnt = '0;
        q.push_back('{cyc + 5, '0});
        repeat (4) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(cnt == '0, "R9 clear beats increment", int'(cnt), 0);
        settle();

        // R10: wrap through all ones at full rate
        for (int i = 0; i < 150; i++) begin
            hold(1'b0, 2);
            hold(1'b1, 2);
        end
        settle();
        check(cnt == m_cnt, "R10 wrapped count", int'(cnt), int'(m_cnt));
        check(cnt == 8'd44, "R10 wrap value", int'(cnt), 44);

        check(q.size() == 0, "R6 pending expectations", q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule